// File: doc/BRIEF.md
# Multi-Bit Stability-Checked Synchronizer

This block carries a slowly changing multi-bit word from a foreign clock domain into the destination clock domain without a FIFO. Every bit goes through its own two-flop synchronizer. The synchronized word then moves through two more destination registers. A value counts as settled only when the synchronizer output and both delayed copies are identical. Until then, a word that is still mid-transition cannot reach the output.

A settled value that differs from the word currently presented is loaded into the output register. A strobe is raised for exactly one destination cycle with that load. After each change the source must hold the word steady for at least four destination cycles. Changes that last only one or two cycles are filtered out.

Top module: `mbit_settle_sync`

## Requirements
- R1: While reset is asserted (`dst_rst_n` low), and on the first sample after release, `out_word` is 0 and `out_strobe` is 0.
- R2: A change on `src_word` sampled at destination edge k shows up on `out_word` at edge k+4. Edges k to k+3 leave the old value in place. `out_strobe` is 1 for the cycle after edge k+4 only.
- R3: `out_word` loads only a value that the synchronizer output and both delayed stages held at the same time in the preceding cycle.
- R4: `out_word` changes only when `out_strobe` is 1, and `out_strobe` is 1 only when `out_word` takes a new value.
- R5: `out_strobe` is never 1 on two consecutive cycles.
- R6: A source value held for four or more destination cycles is always delivered, whatever values came before it.
- R7: A source value held for only one or two destination cycles never reaches `out_word` and raises no strobe.
- R8: A settled value equal to the one already on `out_word` causes no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_clk | input | 1 | Destination clock |
| dst_rst_n | input | 1 | Asynchronous active-low reset, destination domain |
| src_word | input | W | Word from the source domain |
| out_word | output | W | Last accepted stable word |
| out_strobe | output | 1 | One-cycle pulse on each new accepted word |

## Verification
The hardest case to reach from the ports is a word that is present in the pipeline but never stable across all three copies. In that case a partial match must not slip through. The bench reaches it by driving short excursions of one and two cycles away from a settled word, then returning to that word. It checks that neither a load nor a strobe follows. It also drives an excursion of exactly four cycles to mark the edge where capture becomes certain.

// File: rtl/mbit_settle_sync.sv
module mbit_settle_sync #(
  parameter int W = 8
) (
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  input  logic [W-1:0] src_word,
  output logic [W-1:0] out_word,
  output logic         out_strobe
);

  logic [W-1:0] meta_q, sync_q, dly1_q, dly2_q;
  logic         settled, fresh;

  assign settled = (sync_q == dly1_q) && (dly1_q == dly2_q);
  assign fresh   = settled && (sync_q != out_word);

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      dly1_q <= '0;
      dly2_q <= '0;
    end else begin
      meta_q <= src_word;
      sync_q <= meta_q;
      dly1_q <= sync_q;
      dly2_q <= dly1_q;
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      out_word   <= '0;
      out_strobe <= 1'b0;
    end else begin
      out_strobe <= fresh;
      if (fresh) out_word <= sync_q;
    end
  end

  p_shift_r2: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    dly2_q == $past(dly1_q));

  p_load_agreed_r3: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    $changed(out_word) |-> ($past(sync_q) == $past(dly1_q)) &&
                           ($past(dly1_q) == $past(dly2_q)) &&
                           (out_word == $past(sync_q)));

  p_strobe_change_r4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    out_strobe |-> out_word != $past(out_word));

  p_hold_quiet_r4: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !out_strobe |-> $stable(out_word));

  p_single_pulse_r5: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    out_strobe |=> !out_strobe);

  always_ff @(posedge dst_clk) begin
    if (!dst_rst_n) begin
      a_reset_r1: assert (out_word == '0 && !out_strobe);
    end
  end

endmodule

// File: tb/mbit_settle_sync_test.sv
module mbit_settle_sync_test;
  localparam int W = 8;
  localparam int NV = 8;
  localparam logic [15:0] VEC [NV] = '{
    {8'h3C, 8'd6}, {8'hC3, 8'd4}, {8'hFF, 8'd9}, {8'h00, 8'd5},
    {8'h5A, 8'd4}, {8'h5A, 8'd7}, {8'hA5, 8'd12}, {8'h81, 8'd4}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] src = '0;
  logic [W-1:0] q;
  logic         stb;
  int checks = 0, errors = 0, strobes = 0;
  logic [W-1:0] prev;

  always #2 clk = ~clk;

  mbit_settle_sync #(.W(W)) uut (
    .dst_clk(clk), .dst_rst_n(rst_n), .src_word(src),
    .out_word(q), .out_strobe(stb)
  );

  always @(negedge clk) if (rst_n && stb) strobes++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    chk(q == 0 && stb == 0, "R1 in reset", {q, 7'b0, stb}, 0);
    rst_n = 1'b1;
    cyc(1);
    chk(q == 0 && stb == 0, "R1 after release", {q, 7'b0, stb}, 0);

    // R6 / R8: table of held values
    prev = '0;
    for (int v = 0; v < NV; v++) begin
      strobes = 0;
      src = VEC[v][15:8];
      cyc(int'(VEC[v][7:0]) + 2);
      chk(q == VEC[v][15:8], "R6 value delivered", q, VEC[v][15:8]);
      chk(strobes == ((VEC[v][15:8] != prev) ? 1 : 0), "R8 strobe count", strobes,
          (VEC[v][15:8] != prev) ? 1 : 0);
      prev = VEC[v][15:8];
    end

    // R2: exact latency and single pulse (R5)
    src = 8'h17;
    cyc(4);
    chk(q == 8'h81 && !stb, "R2 old value through edge k+3", q, 8'h81);
    cyc(1);
    chk(q == 8'h17 && stb, "R2 new value at edge k+4", {q, 7'b0, stb}, {8'h17, 8'h01});
    cyc(1);
    chk(!stb && q == 8'h17, "R5 strobe one cycle", stb, 0);

    // R7: one and two cycle excursions are filtered
    for (int g = 1; g <= 2; g++) begin
      strobes = 0;
      src = 8'hE7;
      cyc(g);
      src = 8'h17;
      cyc(10);
      chk(q == 8'h17 && strobes == 0, "R7 short excursion filtered", {q, 8'(strobes)}, {8'h17, 8'h00});
    end

    // R6 boundary: four-cycle excursion captured, return also captured
    strobes = 0;
    src = 8'h99;
    cyc(4);
    src = 8'h17;
    cyc(1);
    chk(q == 8'h99, "R6 four-cycle hold captured", q, 8'h99);
    cyc(8);
    chk(q == 8'h17 && strobes == 2, "R3 return settled", {q, 8'(strobes)}, {8'h17, 8'h02});

    // R1: reset mid-operation
    rst_n = 1'b0;
    cyc(1);
    chk(q == 0 && !stb, "R1 reset clears output", q, 0);
    rst_n = 1'b1;
    cyc(8);
    chk(q == 8'h17, "R6 redelivery after reset", q, 8'h17);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule